// File: doc/BRIEF.md
# SPI Serial Clock Generator

This block derives the serial clock of an SPI master from the system clock. A power-of-two prescaler first turns the system clock into a slower tick. Two independent 8-bit counts, measured in those ticks, then set how long the serial clock stays in its high half and in its low half. This lets software choose an uneven duty cycle as well as the rate. The clock polarity input sets the idle level. The phase input decides which of the two edges is the sampling edge and which is the shifting edge.

A sequencer raises `run` to start a burst of serial clocks and lowers it to end the burst. While `run` is high and both counts are nonzero, the generator alternates between a low half and a high half, starting with a low half. When `run` falls, or a count becomes zero, the current half is allowed to finish and the clock then parks at its idle level. It never stops in the middle of a high half. Single-cycle strobes mark each leading edge and each trailing edge, and a shifter can use them directly.

Top module: `spi_sclk_gen`

## Requirements
- R1: After reset and whenever the generator is idle, `busy`, `leadStrobe`, `trailStrobe`, `sampleStrobe` and `shiftStrobe` are 0, and `sclk` equals `cpol` (it is 0 during reset).
- R2: If `run` is 1 and both counts are nonzero at a clock edge while idle, `busy` is 1 from that edge onward. The first leading edge follows `loCount * 2^scaleSel` system cycles later.
- R3: Every high half lasts `hiCount * 2^scaleSel` system cycles and every low half lasts `loCount * 2^scaleSel` system cycles.
- R4: The 4-bit `scaleSel` input divides the system clock by 2 to the power of its value (0 to 15) before the half-period counts are applied.
- R5: If `hiCount` or `loCount` is 0, the generator does not start: `busy` stays 0 and no strobe occurs, whatever the value of `run`.
- R6: With `cpol` = 0 the clock idles low and the leading edge is rising. With `cpol` = 1 the clock is inverted: it idles high and the leading edge is falling.
- R7: `leadStrobe` is high for exactly the one cycle in which `sclk` first shows its non-idle level. `trailStrobe` is high for the one cycle in which `sclk` returns to idle. The two strobes are never high together.
- R8: With `cpha` = 0, `sampleStrobe` equals `leadStrobe` and `shiftStrobe` equals `trailStrobe`. With `cpha` = 1 the two are swapped: sampling is on the trailing edge and shifting on the leading edge.
- R9: If `run` falls during a half, that half runs to its end. If it was a high half, a trailing edge follows and `busy` falls in the same cycle. If it was a low half, `busy` falls with no edge.
- R10: If a count becomes 0 while running, the current half ends at the next prescaled tick and the clock parks as in R9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| run | input | 1 | Sequencer request to generate serial clocks |
| cpol | input | 1 | Clock polarity: 0 idles low, 1 idles high |
| cpha | input | 1 | Clock phase: 0 samples on the leading edge, 1 on the trailing edge |
| scaleSel | input | 4 | Prescaler exponent; tick rate is clk / 2^scaleSel |
| hiCount | input | 8 | High-half length in ticks; 0 disables |
| loCount | input | 8 | Low-half length in ticks; 0 disables |
| sclk | output | 1 | Serial clock, polarity applied |
| leadStrobe | output | 1 | One-cycle pulse on each leading edge |
| trailStrobe | output | 1 | One-cycle pulse on each trailing edge |
| sampleStrobe | output | 1 | Sampling edge pulse selected by `cpha` |
| shiftStrobe | output | 1 | Shifting edge pulse selected by `cpha` |
| busy | output | 1 | Generator is running a burst |

## Verification
All results are registered. Counting `run` taken at an edge as cycle 1:
- `busy` is due at cycle 1.
- The first leading strobe is due at 1 + L·2^s.
- The first trailing strobe is due at 1 + (L+H)·2^s.
- The second leading strobe is due at 1 + (2L+H)·2^s.

Here L is `loCount`, H is `hiCount` and s is `scaleSel`. After `run` falls in a high half, the parking trailing edge and the fall of `busy` are both due at the end of that half. A count zeroed in a high half parks the clock one tick later. The bench drives inputs and samples outputs at the falling clock edge. It counts the cycles from the drive of `run` and compares the cycle number at which each strobe first appears with these formulas.

// File: rtl/spi_sclk_pkg.sv
package spi_sclk_pkg;

  // Commands from the control FSM to the datapath, at most one edge action per cycle
  typedef struct packed {
    logic clear;   // hold counters and raw level at rest
    logic count;   // advance prescaler and half-period counter
    logic toggle;  // end of half: flip the raw level
    logic park;    // end of half: force raw level to idle and stop
  } sclkCtl_t;

  typedef enum logic {
    GEN_IDLE = 1'b0,
    GEN_RUN  = 1'b1
  } genState_t;

endpackage

// File: rtl/sclk_datapath.sv
module sclk_datapath
  import spi_sclk_pkg::*;
#(
  parameter int SCALE_W = 4,
  parameter int CNT_W   = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  sclkCtl_t           ctl,
  input  logic               cpol,
  input  logic               cpha,
  input  logic [SCALE_W-1:0] scaleSel,
  input  logic [CNT_W-1:0]   hiCount,
  input  logic [CNT_W-1:0]   loCount,
  output logic               halfEnd,
  output logic               sclk,
  output logic               leadStrobe,
  output logic               trailStrobe,
  output logic               sampleStrobe,
  output logic               shiftStrobe
);

  // Largest divide is 2^(2^SCALE_W - 1); the prescaler needs that many bits
  localparam int PRE_W = (1 << SCALE_W) - 1;
  localparam logic [PRE_W:0] PRE_ONE = (PRE_W + 1)'(1);
  localparam logic [CNT_W:0] PH_ONE  = (CNT_W + 1)'(1);

  logic [PRE_W-1:0] preCnt;
  logic [PRE_W:0]   preLimitWide;
  logic [PRE_W-1:0] preLimit;
  logic             tick;
  logic [CNT_W-1:0] phCnt;
  logic [CNT_W-1:0] phCur;
  logic             phDone;
  logic             rawQ;
  logic             rawNext;
  logic             sclkQ;
  logic             leadQ;
  logic             trailQ;

  // Prescaler terminal value: 2^scaleSel - 1
  always_comb begin
    preLimitWide = (PRE_ONE << scaleSel) - PRE_ONE;
    preLimit     = preLimitWide[PRE_W-1:0];
  end

  assign tick = (preCnt == preLimit);

  // Half-period length in ticks; a zero length ends the half at the next tick
  assign phCur   = rawQ ? hiCount : loCount;
  assign phDone  = ({1'b0, phCnt} + PH_ONE) >= {1'b0, phCur};
  assign halfEnd = tick && phDone;

  always_comb begin
    if (ctl.clear || ctl.park) begin
      rawNext = 1'b0;
    end else if (ctl.toggle) begin
      rawNext = !rawQ;
    end else begin
      rawNext = rawQ;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      preCnt <= '0;
      phCnt  <= '0;
      rawQ   <= 1'b0;
      sclkQ  <= 1'b0;
      leadQ  <= 1'b0;
      trailQ <= 1'b0;
    end else begin
      if (ctl.clear) begin
        preCnt <= '0;
        phCnt  <= '0;
      end else if (ctl.count) begin
        preCnt <= tick ? '0 : preCnt + PRE_W'(1);
        if (tick) begin
          phCnt <= phDone ? '0 : phCnt + CNT_W'(1);
        end
      end
      rawQ   <= rawNext;
      sclkQ  <= rawNext ^ cpol;
      leadQ  <= ctl.toggle && !rawQ;
      trailQ <= (ctl.toggle || ctl.park) && rawQ;
    end
  end

  assign sclk         = sclkQ;
  assign leadStrobe   = leadQ;
  assign trailStrobe  = trailQ;
  assign sampleStrobe = cpha ? trailQ : leadQ;
  assign shiftStrobe  = cpha ? leadQ : trailQ;

  // R7
  edge_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(leadQ && trailQ));

  // R7
  lead_level_chk: assert property (@(posedge clk) disable iff (!rstN)
    leadQ |-> rawQ);

  // R7
  trail_level_chk: assert property (@(posedge clk) disable iff (!rstN)
    trailQ |-> !rawQ);

  // R9
  always_comb begin
    if (rstN) begin
      ctl_onehot_chk: assert ($onehot0({ctl.toggle, ctl.park, ctl.clear}));
    end
  end

endmodule

// File: rtl/sclk_control.sv
module sclk_control
  import spi_sclk_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             run,
  input  logic [CNT_W-1:0] hiCount,
  input  logic [CNT_W-1:0] loCount,
  input  logic             halfEnd,
  output sclkCtl_t         ctl,
  output logic             busy
);

  genState_t stateQ;
  genState_t stateNext;
  logic      cntOk;
  logic      busyQ;

  assign cntOk = (|hiCount) && (|loCount);
  assign busyQ = (stateQ == GEN_RUN);

  always_comb begin
    ctl       = '0;
    stateNext = stateQ;
    case (stateQ)
      GEN_IDLE: begin
        ctl.clear = 1'b1;
        if (run && cntOk) begin
          stateNext = GEN_RUN;
        end
      end
      GEN_RUN: begin
        ctl.count = 1'b1;
        if (halfEnd) begin
          if (run && cntOk) begin
            ctl.toggle = 1'b1;
          end else begin
            ctl.park  = 1'b1;
            stateNext = GEN_IDLE;
          end
        end
      end
      default: stateNext = GEN_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ <= GEN_IDLE;
    end else begin
      stateQ <= stateNext;
    end
  end

  assign busy = busyQ;

  // R2
  start_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!busyQ && run && cntOk) |=> busyQ);

  // R5
  zero_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!busyQ && !cntOk) |=> !busyQ);

  // R9
  stop_park_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busyQ && halfEnd && !run) |=> !busyQ);

  // R10
  zero_stop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busyQ && halfEnd && !cntOk) |=> !busyQ);

endmodule

// File: rtl/spi_sclk_gen.sv
module spi_sclk_gen
  import spi_sclk_pkg::*;
#(
  parameter int SCALE_W = 4,
  parameter int CNT_W   = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               run,
  input  logic               cpol,
  input  logic               cpha,
  input  logic [SCALE_W-1:0] scaleSel,
  input  logic [CNT_W-1:0]   hiCount,
  input  logic [CNT_W-1:0]   loCount,
  output logic               sclk,
  output logic               leadStrobe,
  output logic               trailStrobe,
  output logic               sampleStrobe,
  output logic               shiftStrobe,
  output logic               busy
);

  sclkCtl_t ctl;
  logic     halfEnd;

  sclk_control #(
    .CNT_W(CNT_W)
  ) u_control (
    .clk    (clk),
    .rstN   (rstN),
    .run    (run),
    .hiCount(hiCount),
    .loCount(loCount),
    .halfEnd(halfEnd),
    .ctl    (ctl),
    .busy   (busy)
  );

  sclk_datapath #(
    .SCALE_W(SCALE_W),
    .CNT_W  (CNT_W)
  ) u_datapath (
    .clk         (clk),
    .rstN        (rstN),
    .ctl         (ctl),
    .cpol        (cpol),
    .cpha        (cpha),
    .scaleSel    (scaleSel),
    .hiCount     (hiCount),
    .loCount     (loCount),
    .halfEnd     (halfEnd),
    .sclk        (sclk),
    .leadStrobe  (leadStrobe),
    .trailStrobe (trailStrobe),
    .sampleStrobe(sampleStrobe),
    .shiftStrobe (shiftStrobe)
  );

endmodule

// File: tb/spi_sclk_gen_bench.sv
`timescale 1ns/1ps
module spi_sclk_gen_bench;

  typedef struct packed {
    logic [3:0] sc;
    logic [7:0] hi;
    logic [7:0] lo;
    logic       pol;
    logic       pha;
  } vec_t;

  localparam int NVEC = 6;
  localparam vec_t VECS [NVEC] = '{
    vec_t'{4'd0, 8'd1,   8'd1, 1'b0, 1'b0},
    vec_t'{4'd0, 8'd3,   8'd2, 1'b1, 1'b0},
    vec_t'{4'd1, 8'd2,   8'd3, 1'b0, 1'b1},
    vec_t'{4'd2, 8'd1,   8'd4, 1'b1, 1'b1},
    vec_t'{4'd3, 8'd5,   8'd2, 1'b0, 1'b0},
    vec_t'{4'd0, 8'd200, 8'd1, 1'b0, 1'b1}
  };

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       run = 1'b0;
  logic       cpol = 1'b0;
  logic       cpha = 1'b0;
  logic [3:0] scaleSel = '0;
  logic [7:0] hiCount = 8'd1;
  logic [7:0] loCount = 8'd1;
  logic       sclk, leadStrobe, trailStrobe, sampleStrobe, shiftStrobe, busy;

  int total = 0;
  int bad = 0;

  always #4 clk = !clk;

  spi_sclk_gen u_spi_sclk_gen (
    .clk         (clk),
    .rstN        (rstN),
    .run         (run),
    .cpol        (cpol),
    .cpha        (cpha),
    .scaleSel    (scaleSel),
    .hiCount     (hiCount),
    .loCount     (loCount),
    .sclk        (sclk),
    .leadStrobe  (leadStrobe),
    .trailStrobe (trailStrobe),
    .sampleStrobe(sampleStrobe),
    .shiftStrobe (shiftStrobe),
    .busy        (busy)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int n, busyAt, stopAt, leads, trails;

    // R1: reset state
    repeat (3) step();
    chk("R1 sclk in reset", int'(sclk), 0);
    rstN = 1'b1;
    step();
    chk("R1 busy idle", int'(busy), 0);
    chk("R1 strobes idle", int'({leadStrobe, trailStrobe, sampleStrobe, shiftStrobe}), 0);
    chk("R1 sclk idle", int'(sclk), 0);
    cpol = 1'b1;
    step();
    chk("R1/R6 idle high with cpol=1", int'(sclk), 1);
    cpol = 1'b0;
    step();

    // Table walk: R2 R3 R4 R6 R7 R8 R9
    for (int v = 0; v < NVEC; v++) begin
      int d, lead1, trail1, lead2, nl;
      int sclkL, samL, shL, sclkT, samT, trailStop;
      d = 1 << VECS[v].sc;
      scaleSel = VECS[v].sc;
      hiCount  = VECS[v].hi;
      loCount  = VECS[v].lo;
      cpol     = VECS[v].pol;
      cpha     = VECS[v].pha;
      step();
      run = 1'b1;
      n = 0; busyAt = -1; stopAt = -1; lead1 = -1; trail1 = -1; lead2 = -1; nl = 0;
      sclkL = 0; samL = 0; shL = 0; sclkT = 0; samT = 0; trailStop = 0;
      while (stopAt < 0 && n < 5000) begin
        step();
        n++;
        if (busy && busyAt < 0) busyAt = n;
        if (leadStrobe) begin
          nl++;
          if (nl == 1) begin
            lead1 = n; sclkL = int'(sclk); samL = int'(sampleStrobe); shL = int'(shiftStrobe);
          end else if (nl == 2) begin
            lead2 = n;
            run = 1'b0;
          end
        end
        if (trailStrobe && trail1 < 0) begin
          trail1 = n; sclkT = int'(sclk); samT = int'(sampleStrobe);
        end
        if (busyAt > 0 && !busy && stopAt < 0) begin
          stopAt = n;
          trailStop = int'(trailStrobe);
        end
      end
      chk("R2 busy rises", busyAt, 1);
      chk("R2 first leading edge time", lead1, 1 + VECS[v].lo * d);
      chk("R3 first trailing edge time", trail1, 1 + (VECS[v].lo + VECS[v].hi) * d);
      chk("R4 second leading edge time", lead2, 1 + (2 * VECS[v].lo + VECS[v].hi) * d);
      chk("R6 sclk at leading edge", sclkL, int'(!VECS[v].pol));
      chk("R6 sclk at trailing edge", sclkT, int'(VECS[v].pol));
      chk("R8 sample at leading edge", samL, int'(!VECS[v].pha));
      chk("R8 shift at leading edge", shL, int'(VECS[v].pha));
      chk("R8 sample at trailing edge", samT, int'(VECS[v].pha));
      chk("R9 stop time after high half", stopAt, 1 + 2 * (VECS[v].lo + VECS[v].hi) * d);
      chk("R7 trailing strobe at park", trailStop, 1);
      step();
      chk("R7 strobe is one cycle", int'(trailStrobe), 0);
      chk("R1 parked level", int'(sclk), int'(VECS[v].pol));
    end

    // R5: zero high count blocks start
    cpol = 1'b0; cpha = 1'b0; scaleSel = 4'd0;
    hiCount = 8'd0; loCount = 8'd3;
    run = 1'b1;
    busyAt = 0; leads = 0;
    for (int i = 0; i < 20; i++) begin
      step();
      busyAt += int'(busy);
      leads += int'(leadStrobe || trailStrobe);
    end
    chk("R5 zero hiCount busy cycles", busyAt, 0);
    chk("R5 zero hiCount strobes", leads, 0);
    run = 1'b0;
    hiCount = 8'd3; loCount = 8'd0;
    run = 1'b1;
    busyAt = 0;
    for (int i = 0; i < 20; i++) begin
      step();
      busyAt += int'(busy);
    end
    chk("R5 zero loCount busy cycles", busyAt, 0);
    run = 1'b0;
    step();

    // R9: run dropped in the low half parks with no edge
    hiCount = 8'd4; loCount = 8'd5;
    run = 1'b1;
    n = 0; stopAt = -1; leads = 0; trails = 0;
    step(); n++;
    step(); n++;
    run = 1'b0;
    while (stopAt < 0 && n < 100) begin
      step(); n++;
      leads += int'(leadStrobe);
      trails += int'(trailStrobe);
      if (!busy) stopAt = n;
    end
    chk("R9 low half stop time", stopAt, 6);
    chk("R9 no leading edge", leads, 0);
    chk("R9 no trailing edge", trails, 0);
    chk("R9 sclk parked", int'(sclk), 0);
    step();

    // R10: count zeroed during a high half parks one tick later
    hiCount = 8'd4; loCount = 8'd4;
    run = 1'b1;
    repeat (5) step();
    chk("R10 leading edge reached", int'(leadStrobe), 1);
    step();
    hiCount = 8'd0;
    step();
    chk("R10 trailing strobe after zero count", int'(trailStrobe), 1);
    chk("R10 busy falls", int'(busy), 0);
    chk("R10 sclk idle", int'(sclk), 0);
    run = 1'b0;
    step();

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule